// File: doc/BRIEF.md
# Clock Multiplier Lock Timer and Pre-Divider Control

This block is the digital control side of a clock-multiplier stage. It keeps one configuration word that selects an input clock, sets a programmable pre-divider on that clock, and gives a multiplier value and a lock-wait count. The analog multiplier is outside the block. The multiplier value is passed through unchanged, and the block only decodes whether it is zero, which means the stage is off. Each write of the configuration word restarts a lock timer, which runs on slow-clock ticks and raises a lock flag when it expires.

Input clocks are given as one-cycle tick pulses on the system clock, one pulse for each rising edge of that input clock. The divided clock is a registered level whose phases are measured in input ticks. A second path produces the 48 MHz peripheral clock from the stage output ticks. That path passes the ticks straight through or halves them. It is blocked whenever the stage is marked as feeding the system clock.

Top module: `pll_ctl`

## Requirements
- R1: Reset clears the configuration word and holds `div_clk`, `locked`, `stage_on`, `periph_use` and `periph_tick` at 0. A cycle with `cfg_we` high loads `cfg_wdata` at that clock edge. The fields are: divider `[7:0]`, lock count `[13:8]`, multiplier `[24:14]`, source select `[25]`, peripheral halve `[26]`, peripheral enable `[27]`. `mult_o` mirrors the multiplier field, and `stage_on` is high exactly when that field is non-zero.
- R2: Source select 0 makes `slow_tick` the divider input, and 1 makes `main_tick` the divider input. Ticks on the input that is not selected leave `div_clk` unchanged.
- R3: A divider ratio of 0 holds `div_clk` at 0 for every input tick.
- R4: A ratio of 1 is a bypass: `div_clk` is 1 in the cycle after each selected tick and 0 in every cycle after a cycle without one.
- R5: An even ratio N divides by N. `div_clk` changes at the clock edge that samples a tick. It is high for the first N/2 ticks of each period and low for the remaining N/2.
- R6: An odd ratio N gives a high phase of (N-1)/2 ticks and a low phase of (N+1)/2 ticks.
- R7: A new ratio is applied only at the tick that ends the current output period. When the active ratio is 0 or 1, every tick ends a period.
- R8: A configuration write clears `locked` at the write edge and reloads the timer with the lock count. With a count C of 1 or more, `locked` rises at the edge that samples the C-th later slow tick. With a count of 0, `locked` rises one cycle after the write.
- R9: While the multiplier field is 0, `locked` stays 0 whatever the lock count and the slow ticks.
- R10: A slow tick in the same cycle as a configuration write is not counted toward the new lock count.
- R11: With peripheral enable 1 and halve 0, `periph_tick` is 1 in the cycle after each `vco_tick`.
- R12: With halve 1, `periph_tick` follows only the 2nd, 4th, 6th and later `vco_tick` after the most recent configuration write.
- R13: While `sys_from_stage` is 1, `periph_use` is 0 and `periph_tick` is 0 in the following cycle, whatever the peripheral enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 28 | Configuration word |
| slow_tick | input | 1 | One pulse per slow-clock edge |
| main_tick | input | 1 | One pulse per main-clock edge |
| vco_tick | input | 1 | One pulse per multiplier output edge |
| sys_from_stage | input | 1 | Stage output drives the system clock |
| div_clk | output | 1 | Pre-divided clock level |
| mult_o | output | 11 | Multiplier value for the analog stage |
| stage_on | output | 1 | Multiplier field is non-zero |
| locked | output | 1 | Lock wait has expired |
| periph_use | output | 1 | Stage currently feeds the peripheral clock |
| periph_tick | output | 1 | Peripheral clock tick |

## Verification
The bench rewrites the ratio in the middle of a divide-by-4 period. A design that applied the new ratio at once would show a shortened period instead of finishing 4 ticks and then running at divide-by-3. The bench also checks the odd-ratio duty, where an off-by-one in the half compare would give a high phase two ticks long. For the lock timer, it puts a slow tick in the same cycle as a write, which would make a counting design lock one tick early, and it uses a zero multiplier, which a careless design would still report as locked. Halved peripheral ticks are counted from the write, so a phase register that is not cleared on a write would produce pulses on the odd ticks.

// File: rtl/pll_ctl_pkg.sv
package pll_ctl_pkg;
   localparam int DIV_W_DEF = 8;
   localparam int CNT_W_DEF = 6;
   localparam int MUL_W_DEF = 11;

   // Way the pre-divider treats the ratio that is currently active
   typedef enum logic [1:0] {
      DM_OFF    = 2'd0,
      DM_PASS   = 2'd1,
      DM_DIVIDE = 2'd2
   } div_mode_e;
endpackage

// File: rtl/pll_ctl_div.sv
module pll_ctl_div
   import pll_ctl_pkg::*;
#(
   parameter int DIV_W = DIV_W_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [DIV_W-1:0] ratio,
   output logic             div_clk
);
   localparam logic [DIV_W-1:0] ONE = DIV_W'(1);
   localparam logic [DIV_W-1:0] TWO = DIV_W'(2);

   logic [DIV_W-1:0] cur_q, cur_d, cnt_q, cnt_d;
   logic             out_q, out_d;
   logic             period_end;

   function automatic div_mode_e classify(input logic [DIV_W-1:0] r);
      if (r == '0)       return DM_OFF;
      else if (r == ONE) return DM_PASS;
      else               return DM_DIVIDE;
   endfunction

   always_comb begin
      period_end = (cur_q < TWO) || (cnt_q == cur_q - ONE);
      cur_d = cur_q;
      cnt_d = cnt_q;
      out_d = out_q;
      if (tick) begin
         if (period_end) begin
            cur_d = ratio;
            cnt_d = '0;
         end else begin
            cnt_d = cnt_q + ONE;
         end
         case (classify(cur_d))
            DM_OFF:  out_d = 1'b0;
            DM_PASS: out_d = 1'b1;
            default: out_d = (cnt_d < (cur_d >> 1));
         endcase
      end else if (classify(cur_q) == DM_PASS) begin
         out_d = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q <= '0;
         cnt_q <= '0;
         out_q <= 1'b0;
      end else begin
         cur_q <= cur_d;
         cnt_q <= cnt_d;
         out_q <= out_d;
      end
   end

   assign div_clk = out_q;

   // R3
   div_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_q == '0) |-> !out_q);

   // R7
   ratio_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cur_q) |-> $past(tick));
endmodule

// File: rtl/pll_ctl_lock.sv
module pll_ctl_lock
   import pll_ctl_pkg::*;
#(
   parameter int CNT_W = CNT_W_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] count,
   input  logic             slow_tick,
   input  logic             active,
   output logic             locked
);
   logic [CNT_W-1:0] rem_q;
   logic             lock_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         lock_q <= 1'b0;
      end else if (load) begin
         rem_q  <= count;
         lock_q <= 1'b0;
      end else begin
         if (slow_tick && (rem_q != '0)) rem_q <= rem_q - CNT_W'(1);
         lock_q <= active && ((rem_q == '0) || (slow_tick && (rem_q == CNT_W'(1))));
      end
   end

   assign locked = lock_q;

   // R9
   lock_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> !lock_q);

   // R8
   lock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(load) |-> !lock_q);
endmodule

// File: rtl/pll_ctl_periph.sv
module pll_ctl_periph #(
   parameter bit HALF_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic vco_tick,
   input  logic enable,
   input  logic half,
   output logic pulse
);
   logic pulse_q;

   generate
      if (HALF_EN) begin : g_half
         logic phase_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               phase_q <= 1'b0;
               pulse_q <= 1'b0;
            end else begin
               if (clear)         phase_q <= 1'b0;
               else if (vco_tick) phase_q <= ~phase_q;
               pulse_q <= vco_tick && enable && (!half || phase_q);
            end
         end
      end else begin : g_direct
         logic unused_half;
         assign unused_half = half ^ clear;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pulse_q <= 1'b0;
            else        pulse_q <= vco_tick && enable;
         end
      end
   endgenerate

   assign pulse = pulse_q;

   // R11
   periph_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !pulse_q);
endmodule

// File: rtl/pll_ctl.sv
module pll_ctl
   import pll_ctl_pkg::*;
#(
   parameter int DIV_W          = DIV_W_DEF,
   parameter int CNT_W          = CNT_W_DEF,
   parameter int MUL_W          = MUL_W_DEF,
   parameter bit PERIPH_HALF_EN = 1'b1,
   localparam int CNT_LSB       = DIV_W,
   localparam int MUL_LSB       = CNT_LSB + CNT_W,
   localparam int SRC_BIT       = MUL_LSB + MUL_W,
   localparam int HALF_BIT      = SRC_BIT + 1,
   localparam int USE_BIT       = HALF_BIT + 1,
   localparam int CFG_W         = USE_BIT + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_wdata,
   input  logic             slow_tick,
   input  logic             main_tick,
   input  logic             vco_tick,
   input  logic             sys_from_stage,
   output logic             div_clk,
   output logic [MUL_W-1:0] mult_o,
   output logic             stage_on,
   output logic             locked,
   output logic             periph_use,
   output logic             periph_tick
);
   generate
      if (DIV_W < 2 || CNT_W < 1 || MUL_W < 1) begin : g_bad_param
         $error("pll_ctl: field widths out of range");
      end
   endgenerate

   logic [CFG_W-1:0] cfg_q;
   logic             sel_tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q <= '0;
      else if (cfg_we) cfg_q <= cfg_wdata;
   end

   assign mult_o     = cfg_q[MUL_LSB +: MUL_W];
   assign stage_on   = (mult_o != '0);
   assign sel_tick   = cfg_q[SRC_BIT] ? main_tick : slow_tick;
   assign periph_use = cfg_q[USE_BIT] && !sys_from_stage;

   pll_ctl_div #(.DIV_W(DIV_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (sel_tick),
      .ratio   (cfg_q[DIV_W-1:0]),
      .div_clk (div_clk)
   );

   pll_ctl_lock #(.CNT_W(CNT_W)) u_lock (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (cfg_we),
      .count     (cfg_wdata[CNT_LSB +: CNT_W]),
      .slow_tick (slow_tick),
      .active    (stage_on),
      .locked    (locked)
   );

   pll_ctl_periph #(.HALF_EN(PERIPH_HALF_EN)) u_periph (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (cfg_we),
      .vco_tick (vco_tick),
      .enable   (periph_use),
      .half     (cfg_q[HALF_BIT]),
      .pulse    (periph_tick)
   );

   // R13
   sys_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sys_from_stage |=> !periph_tick);
endmodule

// File: tb/pll_ctl_bench.sv
module pll_ctl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [27:0] cfg_wdata = '0;
   logic        slow_tick = 1'b0, main_tick = 1'b0, vco_tick = 1'b0;
   logic        sys_from_stage = 1'b0;
   logic        div_clk, stage_on, locked, periph_use, periph_tick;
   logic [10:0] mult_o;

   int checks = 0;
   int errors = 0;
   bit timeout = 1'b0;

   typedef struct {
      int    sig;
      int    exp;
      string tag;
   } item_t;
   item_t exp_q[$];

   always #10 clk = ~clk;

   pll_ctl u_pll_ctl (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .slow_tick(slow_tick), .main_tick(main_tick), .vco_tick(vco_tick),
      .sys_from_stage(sys_from_stage), .div_clk(div_clk), .mult_o(mult_o),
      .stage_on(stage_on), .locked(locked), .periph_use(periph_use),
      .periph_tick(periph_tick)
   );

   // 0 div_clk, 1 locked, 2 periph_tick, 3 periph_use, 4 stage_on, 5 mult_o
   function automatic int actual(input int sig);
      case (sig)
         0: return int'(div_clk);
         1: return int'(locked);
         2: return int'(periph_tick);
         3: return int'(periph_use);
         4: return int'(stage_on);
         default: return int'(mult_o);
      endcase
   endfunction

   function automatic logic [27:0] mk(input int d, input int c, input int m,
                                      input int s, input int h, input int u);
      return {1'(u), 1'(h), 1'(s), 11'(m), 6'(c), 8'(d)};
   endfunction

   function automatic void expect_val(input int sig, input int v, input string tag);
      item_t it;
      it.sig = sig;
      it.exp = v;
      it.tag = tag;
      exp_q.push_back(it);
   endfunction

   // drive at the falling edge, return just after the rising edge
   task automatic step(input bit s, input bit m, input bit v, input bit sys,
                       input bit we, input logic [27:0] w);
      @(negedge clk);
      slow_tick      = s;
      main_tick      = m;
      vco_tick       = v;
      sys_from_stage = sys;
      cfg_we         = we;
      if (we) cfg_wdata = w;
      @(posedge clk);
   endtask

   task automatic idle();
      step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
   endtask

   // monitor: compares everything queued for the edge just passed
   initial begin
      forever begin
         @(posedge clk);
         #5;
         while (exp_q.size() > 0) begin
            item_t it;
            int    a;
            it = exp_q.pop_front();
            a  = actual(it.sig);
            checks++;
            if (a != it.exp) begin
               errors++;
               $display("FAIL %s: signal %0d got %0d expected %0d", it.tag, it.sig, a, it.exp);
            end
         end
      end
   end

   task automatic run_all();
      int d4[8] = '{1, 1, 0, 0, 1, 1, 0, 0};
      int mix[6] = '{1, 0, 0, 1, 0, 0};
      int hv[4] = '{0, 1, 0, 1};
      // R1 reset state
      repeat (3) @(posedge clk);
      expect_val(0, 0, "R1"); expect_val(1, 0, "R1"); expect_val(4, 0, "R1");
      expect_val(3, 0, "R1"); expect_val(2, 0, "R1");
      @(negedge clk); rst_n = 1'b1;
      idle();
      // R1 write: ratio 4, count 3, mult 10, main clock, no halve, enabled
      step(0, 0, 0, 0, 1, mk(4, 3, 10, 1, 0, 1));
      expect_val(1, 0, "R8"); expect_val(4, 1, "R1"); expect_val(5, 10, "R1");
      expect_val(3, 1, "R1");
      // R5 divide by 4 on main ticks
      for (int i = 0; i < 8; i++) begin
         step(0, 1, 0, 0, 0, '0);
         expect_val(0, d4[i], "R5");
         idle();
      end
      // R2 slow ticks ignored by divider, R8 lock after third slow tick
      step(1, 0, 0, 0, 0, '0); expect_val(0, 0, "R2"); expect_val(1, 0, "R8");
      step(1, 0, 0, 0, 0, '0); expect_val(0, 0, "R2"); expect_val(1, 0, "R8");
      step(1, 0, 0, 0, 0, '0); expect_val(1, 1, "R8");
      step(0, 1, 0, 0, 0, '0); expect_val(0, 1, "R5");
      // R7 ratio 3 written mid-period, count 0
      step(0, 0, 0, 0, 1, mk(3, 0, 10, 1, 0, 1)); expect_val(1, 0, "R8");
      idle(); expect_val(1, 1, "R8");
      for (int i = 0; i < 6; i++) begin
         step(0, 1, 0, 0, 0, '0);
         expect_val(0, mix[i], (i < 4) ? "R7" : "R6");
      end
      // R4 bypass
      step(0, 0, 0, 0, 1, mk(1, 0, 10, 1, 0, 1));
      for (int i = 0; i < 2; i++) begin
         step(0, 1, 0, 0, 0, '0); expect_val(0, 1, "R4");
         idle(); expect_val(0, 0, "R4");
      end
      // R3 ratio 0
      step(0, 0, 0, 0, 1, mk(0, 0, 10, 1, 0, 1));
      step(0, 1, 0, 0, 0, '0); expect_val(0, 0, "R3");
      step(0, 1, 0, 0, 0, '0); expect_val(0, 0, "R3");
      idle(); expect_val(0, 0, "R3");
      // R2 slow source, ratio 2, R9 mult 0
      step(0, 0, 0, 0, 1, mk(2, 1, 0, 0, 0, 1)); expect_val(4, 0, "R1");
      step(1, 0, 0, 0, 0, '0); expect_val(0, 1, "R2"); expect_val(1, 0, "R9");
      step(0, 1, 0, 0, 0, '0); expect_val(0, 1, "R2");
      step(1, 0, 0, 0, 0, '0); expect_val(0, 0, "R5"); expect_val(1, 0, "R9");
      step(1, 0, 0, 0, 0, '0); expect_val(0, 1, "R5"); expect_val(1, 0, "R9");
      idle(); expect_val(1, 0, "R9");
      // R10 slow tick coincident with write is not counted
      step(1, 0, 0, 0, 1, mk(0, 2, 5, 1, 0, 1)); expect_val(1, 0, "R10");
      step(1, 0, 0, 0, 0, '0); expect_val(1, 0, "R10");
      step(1, 0, 0, 0, 0, '0); expect_val(1, 1, "R10");
      // R11 direct peripheral ticks
      step(0, 0, 1, 0, 0, '0); expect_val(2, 1, "R11");
      idle(); expect_val(2, 0, "R11");
      // R13 stage feeds system clock
      step(0, 0, 1, 1, 0, '0); expect_val(3, 0, "R13");
      step(0, 0, 1, 1, 0, '0); expect_val(2, 0, "R13"); expect_val(3, 0, "R13");
      idle(); expect_val(2, 0, "R13"); expect_val(3, 1, "R13");
      // R12 halved peripheral ticks counted from the write
      step(0, 0, 0, 0, 1, mk(0, 2, 5, 1, 1, 1));
      for (int i = 0; i < 4; i++) begin
         step(0, 0, 1, 0, 0, '0); expect_val(2, hv[i], "R12");
      end
      idle(); idle();
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (5000) @(posedge clk);
            timeout = 1'b1;
         end
      join_any
      disable fork;
      if (timeout) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run got hung expected completion");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule